// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Flag Unit

This block is the interrupt side of a real-time clock. It watches the current seconds, minutes and hours bytes and, once per second, compares them with three programmable alarm bytes. Any alarm byte whose two top bits are both set acts as a wildcard and accepts every value of its time byte. The block also records two events that come from the rest of the clock: an edge on the chosen periodic divider tap and the end of each time update.

Each of the three events sets its own sticky flag. The flag is set no matter what its enable says. A flag only reaches the interrupt line when software has enabled it. The summary interrupt bit is the OR of the enabled flags, and the registered, active-low interrupt pin follows it. Software programs the alarm bytes and a control byte over a small write bus. It reads status through a read strobe, which captures a status byte and then clears the three flags.

Top module: `rtc_irq_unit`

## Requirements
- R1: After synchronous reset the interrupt pin is high, the captured status byte is 0x00, all flags are clear and every alarm byte and enable is zero.
- R2: The periodic flag (status bit 6) sets on each cycle where `per_edge` is high, whatever the periodic enable is.
- R3: The alarm flag (status bit 5) sets at a `sec_tick` when each of the three time bytes equals its alarm byte (write address 0 = seconds, 1 = minutes, 2 = hours).
- R4: An alarm byte with bits [7:6] = 2'b11 matches any value of its time byte; the other bytes must still match.
- R5: The alarm flag stays clear when any non-wildcard byte differs, and it is never set by a matching time without a `sec_tick`.
- R6: The update-ended flag (status bit 4) sets on each cycle where `upd_end` is high.
- R7: Status bit 7 equals (periodic flag AND enable) OR (alarm flag AND enable) OR (update flag AND enable). The control byte at write address 3 holds the enables in bit 6 (periodic), bit 5 (alarm) and bit 4 (update). `irq_n` is the inverse of that bit, one clock later.
- R8: A cycle with `stat_rd` high loads `stat_q` with {summary, periodic, alarm, update, 4'b0000} as they stand before that edge. The same edge clears all three flags.
- R9: When a flag's event and a status read occur in the same cycle, the flag ends up set.
- R10: A control write with bit 7 (SET) high forces the update enable to 0, whatever data bit 4 holds.
- R11: A flag whose enable is 0 does not pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0..2 alarm bytes, 3 control |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe; clears flags |
| stat_q | output | 8 | Status byte captured by the last read |
| time_sec | input | 8 | Current seconds byte |
| time_min | input | 8 | Current minutes byte |
| time_hr | input | 8 | Current hours byte |
| sec_tick | input | 1 | Once-per-second pulse after the time update |
| per_edge | input | 1 | Edge of the selected periodic tap |
| upd_end | input | 1 | Update-cycle-ended pulse |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The alarm compare is driven with a full exact match, with a single mismatching seconds byte, with a matching time that has no tick, and with wildcard bytes mixed with exact bytes. These cases separate a per-byte wildcard from a global one and show whether the tick gates the compare. The flags are raised with their enables both off and on, which shows the difference between a flag that sets and a flag that interrupts. One case fires an event in the same cycle as a status read. Another writes SET together with the update enable, to show that SET wins.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  // flag indices; their order is the order of status bits [6:4]
  localparam int FLG_UPD = 0;
  localparam int FLG_ALM = 1;
  localparam int FLG_PER = 2;
  localparam int N_FLAGS = 3;

  // control byte bit positions
  localparam int CTL_SET = 7;
  localparam int CTL_PER = 6;
  localparam int CTL_ALM = 5;
  localparam int CTL_UPD = 4;

  typedef logic [N_FLAGS-1:0] flag_vec_t;

  typedef enum logic [1:0] {
    A_ALM_SEC = 2'd0,
    A_ALM_MIN = 2'd1,
    A_ALM_HR  = 2'd2,
    A_CTRL    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int DATA_W  = 8,
  parameter int N_BYTES = 3
) (
  input  logic [N_BYTES*DATA_W-1:0] time_bytes,
  input  logic [N_BYTES*DATA_W-1:0] alarm_bytes,
  output logic                      hit
);
  logic [N_BYTES-1:0] byte_ok;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    logic [DATA_W-1:0] t_b;
    logic [DATA_W-1:0] a_b;
    logic              wild;
    assign t_b  = time_bytes[i*DATA_W +: DATA_W];
    assign a_b  = alarm_bytes[i*DATA_W +: DATA_W];
    assign wild = (a_b[DATA_W-1 -: 2] == 2'b11);
    assign byte_ok[i] = wild || (t_b == a_b);
  end

  assign hit = &byte_ok;
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int N_BYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [N_BYTES*DATA_W-1:0] alarm_bytes,
  output flag_vec_t                 enables
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(A_CTRL);

  for (genvar i = 0; i < N_BYTES; i++) begin : g_alarm
    logic [DATA_W-1:0] alm_q;
    always_ff @(posedge clk) begin
      if (rst)
        alm_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        alm_q <= wr_data;
    end
    assign alarm_bytes[i*DATA_W +: DATA_W] = alm_q;
  end

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      enables <= '0;
    end else if (ctrl_wr) begin
      enables[FLG_PER] <= wr_data[CTL_PER];
      enables[FLG_ALM] <= wr_data[CTL_ALM];
      // SET wins over the update enable in the same write
      enables[FLG_UPD] <= wr_data[CTL_UPD] & ~wr_data[CTL_SET];
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t ev,
  input  logic      clr,
  input  flag_vec_t enables,
  output flag_vec_t flags,
  output logic      irqf
);
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else
        flags[i] <= (flags[i] & ~clr) | ev[i];
    end
  end

  assign irqf = |(flags & enables);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] time_sec,
  input  logic [DATA_W-1:0] time_min,
  input  logic [DATA_W-1:0] time_hr,
  input  logic              sec_tick,
  input  logic              per_edge,
  input  logic              upd_end,
  output logic              irq_n
);
  localparam int N_BYTES = 3;
  localparam int LOW_W   = DATA_W - N_FLAGS - 1;

  logic [N_BYTES*DATA_W-1:0] alarm_bytes;
  flag_vec_t                 enables;
  flag_vec_t                 flags;
  flag_vec_t                 ev;
  logic                      alarm_hit;
  logic                      irqf_w;

  rtc_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_BYTES(N_BYTES)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .alarm_bytes (alarm_bytes),
    .enables     (enables)
  );

  rtc_alarm_cmp #(.DATA_W(DATA_W), .N_BYTES(N_BYTES)) u_cmp (
    .time_bytes  ({time_hr, time_min, time_sec}),
    .alarm_bytes (alarm_bytes),
    .hit         (alarm_hit)
  );

  always_comb begin
    ev          = '0;
    ev[FLG_PER] = per_edge;
    ev[FLG_ALM] = sec_tick & alarm_hit;
    ev[FLG_UPD] = upd_end;
  end

  rtc_irq_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .clr     (stat_rd),
    .enables (enables),
    .flags   (flags),
    .irqf    (irqf_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_n  <= 1'b1;
    end else begin
      irq_n <= ~irqf_w;
      if (stat_rd)
        stat_q <= {irqf_w, flags[FLG_PER], flags[FLG_ALM], flags[FLG_UPD], {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              stat_rd,
  input logic [DATA_W-1:0] stat_q,
  input logic              per_edge,
  input logic              upd_end,
  input logic              sec_tick,
  input logic              alarm_hit,
  input flag_vec_t         flags,
  input flag_vec_t         enables,
  input logic              irqf_w,
  input logic              irq_n
);
  // R2
  per_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    per_edge |=> flags[FLG_PER]);

  // R3
  alarm_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && alarm_hit) |=> flags[FLG_ALM]);

  // R6
  upd_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    upd_end |=> flags[FLG_UPD]);

  // R7
  irq_pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !$past(irqf_w)));

  // R8
  stat_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[DATA_W-N_FLAGS-2:0] == '0);

  // R8
  read_clears_per_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !per_edge) |=> !flags[FLG_PER]);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && upd_end) |=> flags[FLG_UPD]);

  // R10
  set_kills_upd_en_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_CTRL) && wr_data[CTL_SET]) |=> !enables[FLG_UPD]);
endmodule

bind rtc_irq_unit rtc_irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .stat_rd   (stat_rd),
  .stat_q    (stat_q),
  .per_edge  (per_edge),
  .upd_end   (upd_end),
  .sec_tick  (sec_tick),
  .alarm_hit (alarm_hit),
  .flags     (flags),
  .enables   (enables),
  .irqf_w    (irqf_w),
  .irq_n     (irq_n)
);

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_q;
  logic [7:0] time_sec = '0;
  logic [7:0] time_min = '0;
  logic [7:0] time_hr = '0;
  logic       sec_tick = 1'b0;
  logic       per_edge = 1'b0;
  logic       upd_end = 1'b0;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;
  int         wd_cnt = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  rtc_irq_unit u_rtc_irq_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .stat_q(stat_q), .time_sec(time_sec), .time_min(time_min),
    .time_hr(time_hr), .sec_tick(sec_tick), .per_edge(per_edge), .upd_end(upd_end),
    .irq_n(irq_n)
  );

  // monitor: one status result per read, compared against the scoreboard
  always @(posedge clk) rd_d <= stat_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: got stat_q=%h expected none", stat_q);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (stat_q !== e) begin
          n_fail++;
          $display("FAIL %s: stat_q=%h expected %h", t, stat_q, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected under 20000", wd_cnt);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    stat_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic pulse_per();
    per_edge = 1'b1; @(negedge clk); per_edge = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_end = 1'b1; @(negedge clk); upd_end = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq_n !== e) begin
      n_fail++;
      $display("FAIL %s: irq_n=%b expected %b", t, irq_n, e);
    end
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk_irq(1'b1, "R1 reset irq_n");
    n_chk++;
    if (stat_q !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 reset stat_q=%h expected 00", stat_q);
    end
    rd(8'h00, "R1 flags clear after reset");

    // R2 / R11: periodic flag with enable off
    pulse_per();
    idle(1);
    chk_irq(1'b1, "R11 disabled periodic flag");
    rd(8'h40, "R2 periodic flag without enable");
    rd(8'h00, "R8 read cleared flags");

    // R7: periodic with enable on
    wr(2'd3, 8'h40);
    pulse_per();
    idle(1);
    chk_irq(1'b0, "R7 enabled periodic drives irq");
    rd(8'hC0, "R7 summary bit");
    idle(1);
    chk_irq(1'b1, "R8 irq released after read");

    // R3 / R5: exact alarm
    wr(2'd0, 8'h30);
    wr(2'd1, 8'h15);
    wr(2'd2, 8'h08);
    time_sec = 8'h30; time_min = 8'h15; time_hr = 8'h08;
    idle(3);
    rd(8'h00, "R5 match without tick");
    tick();
    idle(1);
    chk_irq(1'b1, "R11 disabled alarm flag");
    rd(8'h20, "R3 exact match at tick");
    time_sec = 8'h31;
    tick();
    rd(8'h00, "R5 seconds mismatch");

    // R4: wildcards
    wr(2'd0, 8'hC0);
    time_sec = 8'h59;
    tick();
    rd(8'h20, "R4 wildcard seconds");
    wr(2'd2, 8'hFF);
    time_min = 8'h16;
    tick();
    rd(8'h00, "R4 exact minutes still compared");
    wr(2'd1, 8'hC7);
    tick();
    rd(8'h20, "R4 all bytes wildcard");

    // R6: update flag
    wr(2'd3, 8'h10);
    pulse_upd();
    idle(1);
    chk_irq(1'b0, "R6 update flag drives irq");
    rd(8'h90, "R6 update flag");
    idle(1);

    // R10: SET clears update enable
    wr(2'd3, 8'h90);
    pulse_upd();
    idle(1);
    chk_irq(1'b1, "R10 SET cleared update enable");
    rd(8'h10, "R10 flag set but not enabled");
    wr(2'd3, 8'h10);
    pulse_upd();
    idle(1);
    chk_irq(1'b0, "R10 update enable restored");
    rd(8'h90, "R10 restored summary");
    idle(1);

    // R9: events in the same cycle as a read
    wr(2'd3, 8'h60);
    idle(1);
    per_edge = 1'b1; sec_tick = 1'b1; stat_rd = 1'b1;
    exp_q.push_back(8'h00);
    tag_q.push_back("R9 read before set");
    @(negedge clk);
    per_edge = 1'b0; sec_tick = 1'b0; stat_rd = 1'b0;
    rd(8'hE0, "R9 set wins over clear");

    // R5: no second alarm without a new tick
    idle(5);
    rd(8'h00, "R5 alarm only on tick");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule